// File: doc/BRIEF.md
# Byte-Access Frame Buffer Network Interface

A register-mapped network interface that holds one receive frame and one transmit frame, each up to 1514 bytes. Software moves every byte through a data register, one access per byte. Incoming frames arrive on a byte stream with start, last and ready signals. Completed transmit frames leave on a byte stream that carries a valid and a last marker and sends one byte per cycle.

A single busy flag gates reception. It is set whenever a frame is received or sent, and it is updated from the interrupt bits on every write to the interrupt-control register. That write clears one interrupt cause, chosen by fixed priority, or it triggers a soft reset of the whole block. The interrupt output is a level that follows the interrupt-control bits. Read data is registered: it appears on `bus_rdata` in the cycle after `bus_rd`, and any side effect of the read takes place at that same clock edge.

Top module: `bytewise_nic`

## Requirements
- R1: The 6-bit byte offset decodes as follows: 0x00 reads 0x4D495053, 0x04 reads 0x4E455430, 0x08 is busy in bit 0, 0x0C is the receive count, 0x10 is the transmit count, 0x14 is interrupt control, 0x18 is interrupt info (reads 0), 0x1C is receive data and 0x20 is transmit data (reads 0). All other offsets read 0.
- R2: After reset, busy reads 1, both counts read 0, interrupt control reads 0, irq is low and rx_ready is low.
- R3: rx_ready is high between frames only when busy is 0 and the receive count is below 1514. A frame shorter than 1514 bytes that ends with rx_last is accepted. Acceptance sets the receive count to the frame length, sets RX done (interrupt-control bit 1) and sets busy.
- R4: A frame that reaches 1514 bytes, with or without a last marker on byte 1514, is dropped. The count, the interrupt bits, busy and the unread bytes of the previous frame stay as they were.
- R5: A read of receive data returns the stored bytes in arrival order. Each read lowers the receive count by one. At a count of zero the read returns 0 and changes nothing.
- R6: A read of interrupt control returns its current value and then clears bit 31.
- R7: A write to interrupt control acts on one cause only. Bit 0 clears TX done. Otherwise bit 1 clears RX done. Otherwise bit 31 soft-resets the block and then sets bit 31. A write of zero changes no bit. After the write, busy equals 1 if any interrupt bit is set and 0 otherwise.
- R8: A write to the transmit count loads the value if it is at most 1514 and loads 0 otherwise. The write also returns the transmit cursor to byte 0.
- R9: A write to transmit data stores bits 7:0 at the cursor and advances the cursor. When the number of stored bytes equals the transmit count, or reaches 1514, the frame is sent. Sending clears the count and the cursor, sets TX done (bit 0) and sets busy.
- R10: A sent frame leaves on tx_data in write order with tx_valid high on consecutive cycles, and tx_last marks the final byte.
- R11: A write to transmit data is ignored while a frame is still streaming out.
- R12: Writes to the ID, busy, receive count, interrupt info and receive data offsets have no effect.
- R13: irq is high exactly when any interrupt-control bit is set, and irq high implies busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_rd | input | 1 | Read strobe, data registered to the next cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Receive byte present |
| rx_start | input | 1 | Receive byte is the first of a frame |
| rx_last | input | 1 | Receive byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block takes the receive byte this cycle |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Transmit byte is the last of the frame |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the receive drop path. It only matters when an earlier frame is still partly unread and busy is already 0, and the oversized frame must run for a full 1514 bytes. The stimulus first receives a short frame. It then clears RX done while leaving the short frame's bytes unread. Next it sends one frame with a last marker on byte 1514 and one that runs past 1514 bytes. Finally it reads back the short frame and expects it unchanged. A second hard case is a transmit-data write that arrives while a frame is still streaming. The bench reloads the transmit count during the stream so that a write accepted in error would show up at once as an extra frame.

// File: rtl/bytewise_nic_pkg.sv
package bytewise_nic_pkg;

  localparam int unsigned FRAME_MAX_DEF = 1514;

  localparam logic [31:0] ID_WORD_LO = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD_HI = 32'h4E45_5430;

  // register offsets (low 6 address bits)
  localparam logic [5:0] OFS_ID_LO  = 6'h00;
  localparam logic [5:0] OFS_ID_HI  = 6'h04;
  localparam logic [5:0] OFS_BUSY   = 6'h08;
  localparam logic [5:0] OFS_RXCNT  = 6'h0C;
  localparam logic [5:0] OFS_TXCNT  = 6'h10;
  localparam logic [5:0] OFS_ICTL   = 6'h14;
  localparam logic [5:0] OFS_INFO   = 6'h18;
  localparam logic [5:0] OFS_RXDAT  = 6'h1C;
  localparam logic [5:0] OFS_TXDAT  = 6'h20;

  typedef struct packed {
    logic test;
    logic rxd;
    logic txd;
  } ictl_t;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_FILL = 2'd1,
    CAP_DROP = 2'd2
  } cap_state_e;

  // interrupt-control register image: bit 0 TX done, bit 1 RX done, bit 31 test
  function automatic logic [31:0] fn_ictl_word(ictl_t v);
    return {v.test, 29'b0, v.rxd, v.txd};
  endfunction

  // transmit count load value: out-of-range requests become zero
  function automatic logic [31:0] fn_tx_clamp(logic [31:0] req, logic [31:0] maxv);
    return (req <= maxv) ? req : 32'd0;
  endfunction

  // frame is complete once the stored byte total hits the count or the cap
  function automatic logic fn_tx_complete(logic [31:0] stored, logic [31:0] cnt,
                                          logic [31:0] maxv);
    return (stored >= maxv) || (stored == cnt);
  endfunction

endpackage

// File: rtl/bytewise_nic_rx_cap.sv
module bytewise_nic_rx_cap
  import bytewise_nic_pkg::*;
#(
  parameter int unsigned FRAME_MAX = FRAME_MAX_DEF,
  localparam int unsigned IDX_W = $clog2(FRAME_MAX),
  localparam int unsigned LEN_W = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             can_accept,
  input  logic             rx_valid,
  input  logic             rx_start,
  input  logic             rx_last,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             commit,
  output logic [LEN_W-1:0] commit_len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);

  localparam logic [LEN_W-1:0] LAST_SLOT = LEN_W'(FRAME_MAX - 1);

  cap_state_e       state_q;
  logic [LEN_W-1:0] fill_q;
  logic             wbank_q;

  logic             in_idle;
  logic             take;
  logic             frame_byte;
  logic [LEN_W-1:0] idx;
  logic             overflow;
  logic             store;
  logic [7:0]       bank_rd [2];

  assign in_idle    = (state_q == CAP_IDLE);
  assign rx_ready   = in_idle ? can_accept : 1'b1;
  assign take       = rx_valid && rx_ready && !soft_rst;
  assign frame_byte = take && ((in_idle && rx_start) || (state_q == CAP_FILL));
  assign idx        = in_idle ? '0 : fill_q;
  assign overflow   = (idx == LAST_SLOT);
  assign store      = frame_byte && !overflow;
  assign commit     = store && rx_last;
  assign commit_len = idx + 1'b1;

  // two banks: one is filled while the other holds the readable frame
  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic BSEL = 1'(b);
    logic [7:0] mem [FRAME_MAX];
    always_ff @(posedge clk) begin
      if (store && (wbank_q == BSEL)) mem[idx[IDX_W-1:0]] <= rx_data;
    end
    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_byte = bank_rd[~wbank_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      fill_q  <= '0;
      wbank_q <= 1'b0;
    end else if (soft_rst) begin
      state_q <= CAP_IDLE;
      fill_q  <= '0;
      wbank_q <= 1'b0;
    end else if (frame_byte) begin
      if (overflow) begin
        state_q <= rx_last ? CAP_IDLE : CAP_DROP;
        fill_q  <= '0;
      end else if (rx_last) begin
        state_q <= CAP_IDLE;
        fill_q  <= '0;
        wbank_q <= ~wbank_q;
      end else begin
        state_q <= CAP_FILL;
        fill_q  <= idx + 1'b1;
      end
    end else if ((state_q == CAP_DROP) && take && rx_last) begin
      state_q <= CAP_IDLE;
    end
  end

endmodule

// File: rtl/bytewise_nic_tx_eng.sv
module bytewise_nic_tx_eng
  import bytewise_nic_pkg::*;
#(
  parameter int unsigned FRAME_MAX = FRAME_MAX_DEF,
  localparam int unsigned IDX_W = $clog2(FRAME_MAX),
  localparam int unsigned LEN_W = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             launch,
  input  logic [LEN_W-1:0] launch_len,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             active
);

  logic [7:0]       mem [FRAME_MAX];
  logic             stream_q;
  logic [IDX_W-1:0] rd_q;
  logic [LEN_W-1:0] len_q;
  logic             valid_q;
  logic             last_q;
  logic [7:0]       data_q;
  logic             at_end;

  assign at_end   = (LEN_W'(rd_q) + 1'b1 == len_q);
  assign active   = stream_q || valid_q;
  assign tx_valid = valid_q;
  assign tx_data  = data_q;
  assign tx_last  = last_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stream_q <= 1'b0;
      rd_q     <= '0;
      len_q    <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      data_q   <= '0;
    end else if (soft_rst) begin
      stream_q <= 1'b0;
      rd_q     <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      if (stream_q) begin
        data_q  <= mem[rd_q];
        valid_q <= 1'b1;
        last_q  <= at_end;
        if (at_end) stream_q <= 1'b0;
        else        rd_q     <= rd_q + 1'b1;
      end else begin
        valid_q <= 1'b0;
        last_q  <= 1'b0;
      end
      if (launch) begin
        stream_q <= 1'b1;
        rd_q     <= '0;
        len_q    <= launch_len;
      end
    end
  end

endmodule

// File: rtl/bytewise_nic.sv
module bytewise_nic
  import bytewise_nic_pkg::*;
#(
  parameter int unsigned FRAME_MAX = FRAME_MAX_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic        rx_start,
  input  logic        rx_last,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        irq
);

  localparam int unsigned IDX_W = $clog2(FRAME_MAX);
  localparam int unsigned LEN_W = $clog2(FRAME_MAX + 1);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(FRAME_MAX);
  localparam logic [31:0] MAX_W = 32'(FRAME_MAX);

  // architectural state
  logic             busy_q,  busy_n;
  ictl_t            ictl_q,  ictl_n;
  logic [LEN_W-1:0] rxc_q,   rxc_n;
  logic [IDX_W-1:0] rcur_q,  rcur_n;
  logic [LEN_W-1:0] txc_q,   txc_n;
  logic [IDX_W-1:0] tcur_q,  tcur_n;
  logic [31:0]      rdata_q, rd_word;

  // named events, also observed by the checker
  logic             rd_ictl, rd_rxdat;
  logic             wr_ictl, wr_txcnt, wr_txdat;
  logic             ev_soft_reset;
  logic             ev_rx_commit;
  logic             ev_rx_pop;
  logic             ev_tx_take;
  logic             ev_tx_launch;

  logic             cap_commit;
  logic [LEN_W-1:0] cap_len;
  logic [7:0]       rx_byte;
  logic             tx_active;
  logic [LEN_W-1:0] tx_stored;

  assign rd_ictl  = bus_rd && (bus_addr == OFS_ICTL);
  assign rd_rxdat = bus_rd && (bus_addr == OFS_RXDAT);
  assign wr_ictl  = bus_wr && (bus_addr == OFS_ICTL);
  assign wr_txcnt = bus_wr && (bus_addr == OFS_TXCNT);
  assign wr_txdat = bus_wr && (bus_addr == OFS_TXDAT);

  assign ev_soft_reset = wr_ictl && !bus_wdata[0] && !bus_wdata[1] && bus_wdata[31];
  assign ev_rx_commit  = cap_commit && !ev_soft_reset;
  assign ev_rx_pop     = rd_rxdat && (rxc_q != '0) && !ev_rx_commit && !ev_soft_reset;
  assign ev_tx_take    = wr_txdat && !tx_active;
  assign tx_stored     = LEN_W'(tcur_q) + 1'b1;
  assign ev_tx_launch  = ev_tx_take &&
                         fn_tx_complete(32'(tx_stored), 32'(txc_q), MAX_W);

  bytewise_nic_rx_cap #(.FRAME_MAX(FRAME_MAX)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (ev_soft_reset),
    .can_accept (!busy_q && (rxc_q < MAX_L)),
    .rx_valid   (rx_valid),
    .rx_start   (rx_start),
    .rx_last    (rx_last),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .commit     (cap_commit),
    .commit_len (cap_len),
    .rd_idx     (rcur_q),
    .rd_byte    (rx_byte)
  );

  bytewise_nic_tx_eng #(.FRAME_MAX(FRAME_MAX)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (ev_soft_reset),
    .wr_en      (ev_tx_take),
    .wr_idx     (tcur_q),
    .wr_byte    (bus_wdata[7:0]),
    .launch     (ev_tx_launch),
    .launch_len (tx_stored),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_last    (tx_last),
    .active     (tx_active)
  );

  // read multiplexer
  always_comb begin
    case (bus_addr)
      OFS_ID_LO: rd_word = ID_WORD_LO;
      OFS_ID_HI: rd_word = ID_WORD_HI;
      OFS_BUSY:  rd_word = {31'b0, busy_q};
      OFS_RXCNT: rd_word = 32'(rxc_q);
      OFS_TXCNT: rd_word = 32'(txc_q);
      OFS_ICTL:  rd_word = fn_ictl_word(ictl_q);
      OFS_RXDAT: rd_word = (rxc_q != '0) ? {24'b0, rx_byte} : 32'd0;
      default:   rd_word = 32'd0;
    endcase
  end

  // next state: later statements take precedence over earlier ones
  always_comb begin
    busy_n = busy_q;
    ictl_n = ictl_q;
    rxc_n  = rxc_q;
    rcur_n = rcur_q;
    txc_n  = txc_q;
    tcur_n = tcur_q;

    if (rd_ictl) ictl_n.test = 1'b0;

    if (ev_rx_pop) begin
      rxc_n  = rxc_q - 1'b1;
      rcur_n = rcur_q + 1'b1;
    end

    if (wr_txcnt) begin
      txc_n  = LEN_W'(fn_tx_clamp(bus_wdata, MAX_W));
      tcur_n = '0;
    end

    if (ev_tx_take) begin
      if (ev_tx_launch) begin
        txc_n      = '0;
        tcur_n     = '0;
        ictl_n.txd = 1'b1;
        busy_n     = 1'b1;
      end else begin
        tcur_n = tcur_q + 1'b1;
      end
    end

    if (wr_ictl) begin
      if (bus_wdata[0]) begin
        ictl_n.txd = 1'b0;
      end else if (bus_wdata[1]) begin
        ictl_n.rxd = 1'b0;
      end else if (bus_wdata[31]) begin
        rxc_n  = '0;
        rcur_n = '0;
        txc_n  = '0;
        tcur_n = '0;
        ictl_n = '{test: 1'b1, rxd: 1'b0, txd: 1'b0};
      end
      busy_n = ictl_n.txd || ictl_n.rxd || ictl_n.test;
    end

    if (ev_rx_commit) begin
      rxc_n      = cap_len;
      rcur_n     = '0;
      ictl_n.rxd = 1'b1;
      busy_n     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      ictl_q  <= '0;
      rxc_q   <= '0;
      rcur_q  <= '0;
      txc_q   <= '0;
      tcur_q  <= '0;
      rdata_q <= '0;
    end else begin
      busy_q <= busy_n;
      ictl_q <= ictl_n;
      rxc_q  <= rxc_n;
      rcur_q <= rcur_n;
      txc_q  <= txc_n;
      tcur_q <= tcur_n;
      if (bus_rd) rdata_q <= rd_word;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |ictl_q;

endmodule

// File: rtl/bytewise_nic_chk.sv
module bytewise_nic_chk #(
  parameter int unsigned FRAME_MAX = 1514,
  localparam int unsigned LEN_W = $clog2(FRAME_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             busy,
  input logic             ictl_txd,
  input logic             ictl_rxd,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             ev_tx_launch,
  input logic             ev_rx_pop,
  input logic             ev_rx_commit,
  input logic [LEN_W-1:0] rxc,
  input logic [LEN_W-1:0] txc
);

  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(FRAME_MAX);

  // R13: an interrupt level is never seen with busy clear
  a_r13_irq_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);

  // R3: an accepted frame leaves a nonzero count, RX done and busy behind
  a_r3_commit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_commit |=> (rxc != '0) && ictl_rxd && busy);

  // R9: a completed transmit frame sets TX done and busy, count cleared
  a_r9_launch_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_launch |=> ictl_txd && busy && (txc == '0));

  // R10: the stream only stops right after a byte marked last
  a_r10_stream_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> $past(tx_last));

  // R5: each receive-data pop lowers the count by exactly one
  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pop |=> (rxc == LEN_W'($past(rxc) - 1'b1)));

  // R8: the transmit count never exceeds the frame cap
  a_r8_txcount_bound: assert property (@(posedge clk) disable iff (!rst_n)
    txc <= MAX_L);

endmodule

bind bytewise_nic bytewise_nic_chk #(.FRAME_MAX(FRAME_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .busy         (busy_q),
  .ictl_txd     (ictl_q.txd),
  .ictl_rxd     (ictl_q.rxd),
  .tx_valid     (tx_valid),
  .tx_last      (tx_last),
  .ev_tx_launch (ev_tx_launch),
  .ev_rx_pop    (ev_rx_pop),
  .ev_rx_commit (ev_rx_commit),
  .rxc          (rxc_q),
  .txc          (txc_q)
);

// File: tb/bytewise_nic_tb.sv
`timescale 1ns/1ps
module bytewise_nic_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_start = 1'b0;
  logic        rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // offsets as the bench understands the map
  localparam logic [5:0] A_ID0 = 6'h00, A_ID1 = 6'h04, A_BUSY = 6'h08,
                         A_RXC = 6'h0C, A_TXC = 6'h10, A_ICTL = 6'h14,
                         A_INFO = 6'h18, A_RXD = 6'h1C, A_TXD = 6'h20;

  always #10 clk = ~clk;

  bytewise_nic u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_start(rx_start), .rx_last(rx_last),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .irq(irq)
  );

  // transmit stream monitor
  logic [7:0] txcap [64];
  int  txn = 0;
  int  tx_frames = 0;
  int  tx_gaps = 0;
  bit  tx_in = 0;
  always @(negedge clk) begin
    if (tx_valid) begin
      if (txn < 64) txcap[txn] = tx_data;
      txn++;
      tx_in = !tx_last;
      if (tx_last) tx_frames++;
    end else if (tx_in) begin
      tx_gaps++;
      tx_in = 0;
    end
  end

  function automatic logic [7:0] exp_byte(int seed, int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_send(int len, int seed, bit with_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_start = (i == 0);
      rx_last  = with_last && (i == len - 1);
      rx_data  = exp_byte(seed, i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_start = 1'b0; rx_last = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(A_BUSY, v); check_eq("R2 busy after reset", v, 32'd1);
    bus_read(A_RXC, v);  check_eq("R2 rx count after reset", v, 32'd0);
    bus_read(A_TXC, v);  check_eq("R2 tx count after reset", v, 32'd0);
    bus_read(A_ICTL, v); check_eq("R2 intctl after reset", v, 32'd0);
    check_eq("R2 irq after reset", 32'(irq), 32'd0);
    check_eq("R2 rx_ready after reset", 32'(rx_ready), 32'd0);
  endtask

  task automatic t_id_map();
    logic [31:0] v;
    bus_read(A_ID0, v);  check_eq("R1 id low word", v, 32'h4D495053);
    bus_read(A_ID1, v);  check_eq("R1 id high word", v, 32'h4E455430);
    bus_read(A_INFO, v); check_eq("R1 info reads zero", v, 32'd0);
    bus_read(A_TXD, v);  check_eq("R1 tx data reads zero", v, 32'd0);
    bus_read(6'h24, v);  check_eq("R1 unmapped 0x24", v, 32'd0);
    bus_read(6'h3C, v);  check_eq("R1 unmapped 0x3C", v, 32'd0);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    bus_write(A_ICTL, 32'd0);
    bus_read(A_BUSY, v); check_eq("R7 zero write clears busy", v, 32'd0);
    check_eq("R3 rx_ready when idle", 32'(rx_ready), 32'd1);
  endtask

  task automatic t_rx_frame();
    logic [31:0] v;
    rx_send(5, 8'h31, 1'b1);
    check_eq("R3 rx_ready low after accept", 32'(rx_ready), 32'd0);
    check_eq("R13 irq after accept", 32'(irq), 32'd1);
    bus_read(A_RXC, v);  check_eq("R3 rx count", v, 32'd5);
    bus_read(A_ICTL, v); check_eq("R3 rx done bit", v, 32'd2);
    bus_write(A_RXC, 32'h55);
    bus_write(A_BUSY, 32'd0);
    bus_write(A_ID0, 32'd0);
    bus_write(A_RXD, 32'hAB);
    bus_write(A_INFO, 32'h7);
    bus_read(A_RXC, v);  check_eq("R12 rx count unchanged", v, 32'd5);
    bus_read(A_BUSY, v); check_eq("R12 busy unchanged", v, 32'd1);
    bus_read(A_ID0, v);  check_eq("R12 id unchanged", v, 32'h4D495053);
    for (int i = 0; i < 5; i++) begin
      bus_read(A_RXD, v);
      check_eq("R5 rx byte", v, 32'(exp_byte(8'h31, i)));
    end
    bus_read(A_RXC, v); check_eq("R5 count drained", v, 32'd0);
    bus_read(A_RXD, v); check_eq("R5 empty read returns zero", v, 32'd0);
    bus_read(A_RXC, v); check_eq("R5 empty read keeps count", v, 32'd0);
  endtask

  task automatic t_tx_frame();
    logic [31:0] v;
    txn = 0; tx_frames = 0; tx_gaps = 0;
    bus_write(A_TXC, 32'd4);
    for (int i = 0; i < 4; i++) bus_write(A_TXD, 32'hFFFF_FFA0 + 32'(i));
    repeat (8) @(negedge clk);
    check_eq("R10 tx byte total", 32'(txn), 32'd4);
    for (int i = 0; i < 4; i++) check_eq("R10 tx byte", 32'(txcap[i]), 32'hA0 + 32'(i));
    check_eq("R10 one last marker", 32'(tx_frames), 32'd1);
    check_eq("R10 contiguous valid", 32'(tx_gaps), 32'd0);
    bus_read(A_TXC, v);  check_eq("R9 tx count cleared", v, 32'd0);
    bus_read(A_ICTL, v); check_eq("R9 tx done with rx done", v, 32'd3);
    check_eq("R13 irq with two causes", 32'(irq), 32'd1);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    bus_write(A_TXC, 32'd9);
    bus_write(A_ICTL, 32'd3);
    bus_read(A_ICTL, v); check_eq("R7 bit0 wins over bit1", v, 32'd2);
    bus_read(A_BUSY, v); check_eq("R7 busy stays with rx done", v, 32'd1);
    bus_write(A_ICTL, 32'h8000_0002);
    bus_read(A_ICTL, v); check_eq("R7 bit1 wins over bit31", v, 32'd0);
    bus_read(A_TXC, v);  check_eq("R7 no soft reset on bit1", v, 32'd9);
    bus_read(A_BUSY, v); check_eq("R7 busy clears with no cause", v, 32'd0);
    check_eq("R13 irq low with no cause", 32'(irq), 32'd0);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    bus_write(A_TXC, 32'd1515);
    bus_read(A_TXC, v); check_eq("R8 over cap loads zero", v, 32'd0);
    bus_write(A_TXC, 32'hFFFF_FFFF);
    bus_read(A_TXC, v); check_eq("R8 huge loads zero", v, 32'd0);
    bus_write(A_TXC, 32'd1514);
    bus_read(A_TXC, v); check_eq("R8 cap loads", v, 32'd1514);
    txn = 0; tx_frames = 0;
    bus_write(A_TXC, 32'd3);
    bus_write(A_TXD, 32'h11);
    bus_write(A_TXC, 32'd2);
    bus_write(A_TXD, 32'h22);
    bus_write(A_TXD, 32'h33);
    repeat (6) @(negedge clk);
    check_eq("R8 cursor reset frame size", 32'(txn), 32'd2);
    check_eq("R8 cursor reset byte0", 32'(txcap[0]), 32'h22);
    check_eq("R8 cursor reset byte1", 32'(txcap[1]), 32'h33);
    bus_write(A_ICTL, 32'd1);
    bus_read(A_BUSY, v); check_eq("R7 busy clears after tx ack", v, 32'd0);
  endtask

  task automatic t_tx_ignore();
    logic [31:0] v;
    txn = 0; tx_frames = 0; tx_gaps = 0;
    bus_write(A_TXC, 32'd16);
    for (int i = 0; i < 16; i++) bus_write(A_TXD, 32'h40 + 32'(i));
    bus_write(A_TXC, 32'd1);
    bus_write(A_TXD, 32'hEE);
    repeat (24) @(negedge clk);
    check_eq("R11 stream length", 32'(txn), 32'd16);
    check_eq("R11 no extra frame", 32'(tx_frames), 32'd1);
    check_eq("R11 last byte intact", 32'(txcap[15]), 32'h4F);
    bus_write(A_TXD, 32'h5A);
    repeat (6) @(negedge clk);
    check_eq("R11 next frame sent", 32'(tx_frames), 32'd2);
    check_eq("R11 next frame byte", 32'(txcap[16]), 32'h5A);
    check_eq("R10 no gaps", 32'(tx_gaps), 32'd0);
    bus_write(A_ICTL, 32'd1);
    bus_read(A_ICTL, v); check_eq("R7 tx done cleared", v, 32'd0);
  endtask

  task automatic t_test_bit();
    logic [31:0] v;
    bus_write(A_TXC, 32'd5);
    bus_write(A_ICTL, 32'h8000_0000);
    check_eq("R13 irq on test bit", 32'(irq), 32'd1);
    check_eq("R7 rx_ready low after soft reset", 32'(rx_ready), 32'd0);
    bus_read(A_TXC, v);  check_eq("R7 soft reset clears tx count", v, 32'd0);
    bus_read(A_BUSY, v); check_eq("R7 busy after soft reset", v, 32'd1);
    bus_read(A_ICTL, v); check_eq("R6 first read sees test bit", v, 32'h8000_0000);
    bus_read(A_ICTL, v); check_eq("R6 test bit cleared by read", v, 32'd0);
    check_eq("R13 irq low after test read", 32'(irq), 32'd0);
    bus_read(A_BUSY, v); check_eq("R6 read leaves busy", v, 32'd1);
    bus_write(A_ICTL, 32'd0);
    bus_read(A_BUSY, v); check_eq("R7 ack releases busy", v, 32'd0);
  endtask

  task automatic t_rx_oversize();
    logic [31:0] v;
    rx_send(3, 8'h10, 1'b1);
    bus_write(A_ICTL, 32'd2);
    check_eq("R3 ready with bytes pending", 32'(rx_ready), 32'd1);
    rx_send(1514, 8'h90, 1'b1);
    check_eq("R4 no irq after 1514 frame", 32'(irq), 32'd0);
    bus_read(A_RXC, v);  check_eq("R4 count after 1514 frame", v, 32'd3);
    rx_send(1516, 8'h55, 1'b1);
    bus_read(A_RXC, v);  check_eq("R4 count after long frame", v, 32'd3);
    bus_read(A_ICTL, v); check_eq("R4 intctl after long frame", v, 32'd0);
    bus_read(A_BUSY, v); check_eq("R4 busy after long frame", v, 32'd0);
    for (int i = 0; i < 3; i++) begin
      bus_read(A_RXD, v);
      check_eq("R4 old frame bytes kept", v, 32'(exp_byte(8'h10, i)));
    end
    rx_send(1513, 8'h22, 1'b1);
    bus_read(A_RXC, v);  check_eq("R3 1513 byte frame accepted", v, 32'd1513);
    bus_read(A_ICTL, v); check_eq("R3 rx done on 1513", v, 32'd2);
    bus_read(A_RXD, v);  check_eq("R5 long frame byte0", v, 32'(exp_byte(8'h22, 0)));
    bus_read(A_RXD, v);  check_eq("R5 long frame byte1", v, 32'(exp_byte(8'h22, 1)));
    bus_read(A_RXC, v);  check_eq("R5 long frame count", v, 32'd1511);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id_map();
    t_ack();
    t_rx_frame();
    t_tx_frame();
    t_priority();
    t_clamp();
    t_tx_ignore();
    t_test_bit();
    t_rx_oversize();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule